// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetcher

This block sits beside a level-one cache and holds several short queues of cache lines, each queue following its own run of ascending line addresses. Every lookup that the cache performs is presented here in the same cycle. When the cache itself misses, the block compares the line address against the oldest entry of each queue only. If one of them matches, that line is handed to the cache refill path on the next cycle and the queue moves forward. If none matches, the least recently used queue is emptied and restarted on the lines that follow the missed one.

Each queue asks the lower memory for its next sequential line whenever it has room. Requests leave through one valid/ready port: the block raises valid with an address and a tag made of the queue number and that queue's generation count, and keeps all fields steady until ready is seen high at a clock edge. Responses return on a valid-only port that is always accepted. They carry the same tag and must come back in issue order within each queue. A response whose generation no longer matches its queue, because the queue was restarted after the request left, is thrown away. The refill output has no back-pressure; the cache takes each line in the cycle it appears.

Line addresses are 27 bits wide, which is a 32-byte line inside a 32-bit byte address. Queue count, queue depth (a power of two), line payload width and generation width are parameters.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset no queue is active: `refill_valid` and `mem_req_valid` stay low, and nothing is requested until the first lookup miss.
- R2: A lookup with `lk_valid` high, `lk_l1_hit` low and no head match at line address k restarts the least recently used queue. That queue then requests lines k+1, k+2, ... in order, each carrying the queue number in `mem_req_sid`. Reset order treats queue NSTREAM-1 as least recent and queue 0 as most recent.
- R3: A queue never holds more than DEPTH lines counting both stored lines and requests in flight; with no lookups, an active queue issues exactly DEPTH requests after its restart.
- R4: A lookup whose line address equals a stored head line (with `lk_l1_hit` low) drives `refill_valid` high on the next cycle with `refill_addr` equal to the lookup address and that line's payload on `refill_data`. The head is removed, and the freed slot leads to one request for the queue's next sequential address.
- R5: Only head entries are compared: an address held deeper in a queue is treated as a miss and causes a restart.
- R6: A lookup with `lk_l1_hit` high has no effect: no refill, no head removal, no restart and no change in recency.
- R7: A head hit makes that queue the most recently used; a restart makes the restarted queue the most recently used; the restart target is always the least recently used queue.
- R8: Every restart advances the queue's generation; a response whose `mem_rsp_gen` differs from the current generation of queue `mem_rsp_sid` is discarded and stores nothing.
- R9: While `mem_req_valid` is high and `mem_req_ready` low, `mem_req_valid`, `mem_req_addr`, `mem_req_sid` and `mem_req_gen` hold their values.
- R10: At most one request is issued per cycle; among queues with free room, the grant goes round-robin, starting after the queue granted last (queue 0 first after reset).
- R11: When several queues hold the looked-up line at their heads, only the lowest-numbered one supplies and removes it; the others keep their heads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A cache lookup is presented this cycle |
| lk_addr | input | LA_W | Line address of the lookup |
| lk_l1_hit | input | 1 | The level-one cache hit on this lookup |
| refill_valid | output | 1 | A prefetched line is delivered this cycle |
| refill_addr | output | LA_W | Line address of the delivered line |
| refill_data | output | LINE_W | Payload of the delivered line |
| mem_req_valid | output | 1 | Line request to lower memory is pending |
| mem_req_ready | input | 1 | Lower memory accepts the pending request |
| mem_req_addr | output | LA_W | Requested line address |
| mem_req_sid | output | SID_W | Queue number of the request |
| mem_req_gen | output | GEN_W | Queue generation at issue |
| mem_rsp_valid | input | 1 | A line response is present |
| mem_rsp_sid | input | SID_W | Queue number echoed from the request |
| mem_rsp_gen | input | GEN_W | Generation echoed from the request |
| mem_rsp_data | input | LINE_W | Returned line payload |

## Verification
A corrupted head pointer or tag shows up on the first lookup of that queue: the refill carries the wrong payload, or a hit turns into a miss and a new run of requests starts one cycle later under another queue number. A wrong occupancy count appears within a few cycles of a restart as a request count other than DEPTH, or as an endless request stream. Recency errors surface on the next miss, when the queue number of the first request names the wrong queue. A missing generation check is exposed as soon as a stale response lands, because the next head payload no longer matches its address.

// File: rtl/spf_pkg.sv
package spf_pkg;

  localparam int unsigned SPF_NSTREAM = 4;
  localparam int unsigned SPF_DEPTH   = 4;
  localparam int unsigned SPF_LA_W    = 27;
  localparam int unsigned SPF_LINE_W  = 64;
  localparam int unsigned SPF_GEN_W   = 3;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_BYPASS = 2'd1,
    LK_HIT    = 2'd2,
    LK_MISS   = 2'd3
  } spf_lk_e;

endpackage

// File: rtl/spf_stream.sv
module spf_stream #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LA_W   = 27,
  parameter int unsigned LINE_W = 64,
  parameter int unsigned GEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [LA_W-1:0]   alloc_addr_i,
  input  logic              grant_i,
  input  logic              pop_i,
  input  logic              rsp_wr_i,
  input  logic [GEN_W-1:0]  rsp_gen_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output logic              room_o,
  output logic              head_vld_o,
  output logic [LA_W-1:0]   head_tag_o,
  output logic [LINE_W-1:0] head_data_o,
  output logic [LA_W-1:0]   next_addr_o,
  output logic [GEN_W-1:0]  gen_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [LA_W-1:0]   tag_q  [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q;
  logic [CNT_W-1:0]  full_q, pend_q;
  logic [LA_W-1:0]   next_q;
  logic [GEN_W-1:0]  gen_q;
  logic              active_q;

  logic [CNT_W:0]    occ;
  logic [PTR_W-1:0]  fill_slot, resv_slot;
  logic              rsp_take;

  assign occ       = {1'b0, full_q} + {1'b0, pend_q};
  assign fill_slot = rd_ptr_q + full_q[PTR_W-1:0];
  assign resv_slot = rd_ptr_q + occ[PTR_W-1:0];
  assign rsp_take  = rsp_wr_i && (rsp_gen_i == gen_q) && (pend_q != '0) && !alloc_i;

  assign room_o      = active_q && (occ < (CNT_W+1)'(DEPTH));
  assign head_vld_o  = (full_q != '0);
  assign head_tag_o  = tag_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign next_addr_o = next_q;
  assign gen_o       = gen_q;

  // control state: counts, pointer, sequential address, generation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_ptr_q <= '0;
      full_q   <= '0;
      pend_q   <= '0;
      next_q   <= '0;
      gen_q    <= '0;
    end else if (alloc_i) begin
      active_q <= 1'b1;
      rd_ptr_q <= '0;
      full_q   <= '0;
      pend_q   <= '0;
      next_q   <= alloc_addr_i + LA_W'(1);
      gen_q    <= gen_q + GEN_W'(1);
    end else begin
      full_q   <= full_q + CNT_W'(rsp_take) - CNT_W'(pop_i);
      pend_q   <= pend_q + CNT_W'(grant_i) - CNT_W'(rsp_take);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_i);
      if (grant_i) next_q <= next_q + LA_W'(1);
    end
  end

  // line storage: tag written when the slot is reserved, payload on return
  always_ff @(posedge clk) begin
    if (grant_i && !alloc_i) tag_q[resv_slot] <= next_q;
    if (rsp_take)            data_q[fill_slot] <= rsp_data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (CNT_W+1)'(DEPTH)); // R3
  AST_POP_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> head_vld_o); // R4
  AST_GRANT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> room_o); // R10
  AST_RESTART_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> !head_vld_o); // R8

endmodule

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int unsigned N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch_i,
  input  logic [$clog2(N)-1:0] touch_id_i,
  output logic [$clog2(N)-1:0] victim_o
);

  localparam int unsigned IDW = $clog2(N);

  logic [IDW-1:0] age_q [N];
  logic [N-1:0]   oldest, newest;
  logic [IDW-1:0] touched_age;

  assign touched_age = age_q[touch_id_i];

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      oldest[i] = (age_q[i] == IDW'(N - 1));
      newest[i] = (age_q[i] == '0);
      if (oldest[i]) victim_o = IDW'(i);
    end
  end

  // age 0 = most recent, N-1 = least recent
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) age_q[i] <= IDW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < int'(N); i++) begin
        if (IDW'(i) == touch_id_i)       age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + IDW'(1);
      end
    end
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest)); // R7
  AST_LRU_ONE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(newest) == 1); // R7
  AST_TOUCH_BECOMES_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> victim_o != $past(touch_id_i)); // R7

endmodule

// File: rtl/spf_rr_arb.sv
module spf_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [N-1:0]         req_i,
  output logic [N-1:0]         gnt_o,
  output logic [$clog2(N)-1:0] gnt_id_o
);

  localparam int unsigned IDW = $clog2(N);

  logic [IDW-1:0] last_q;
  logic           found;
  int             idx;

  always_comb begin
    gnt_o    = '0;
    gnt_id_o = '0;
    found    = 1'b0;
    idx      = 0;
    for (int k = 1; k <= int'(N); k++) begin
      idx = (int'(last_q) + k) % int'(N);
      if (!found && en_i && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        gnt_id_o   = IDW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= IDW'(N - 1);
    else if (found) last_q <= gnt_id_o;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R10
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0); // R10

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import spf_pkg::*;
#(
  parameter int unsigned NSTREAM = SPF_NSTREAM,
  parameter int unsigned DEPTH   = SPF_DEPTH,
  parameter int unsigned LA_W    = SPF_LA_W,
  parameter int unsigned LINE_W  = SPF_LINE_W,
  parameter int unsigned GEN_W   = SPF_GEN_W,
  localparam int unsigned SID_W  = $clog2(NSTREAM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [LA_W-1:0]   lk_addr,
  input  logic              lk_l1_hit,
  output logic              refill_valid,
  output logic [LA_W-1:0]   refill_addr,
  output logic [LINE_W-1:0] refill_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LA_W-1:0]   mem_req_addr,
  output logic [SID_W-1:0]  mem_req_sid,
  output logic [GEN_W-1:0]  mem_req_gen,
  input  logic              mem_rsp_valid,
  input  logic [SID_W-1:0]  mem_rsp_sid,
  input  logic [GEN_W-1:0]  mem_rsp_gen,
  input  logic [LINE_W-1:0] mem_rsp_data
);

  logic [LA_W-1:0]   hd_tag  [NSTREAM];
  logic [LINE_W-1:0] hd_data [NSTREAM];
  logic [LA_W-1:0]   nx_addr [NSTREAM];
  logic [GEN_W-1:0]  st_gen  [NSTREAM];
  logic [NSTREAM-1:0] hd_vld, room, head_match, alloc, pop, grant, rsp_wr;

  logic [SID_W-1:0] hit_id, victim_id, gnt_id, touch_id;
  logic             hit_any, can_issue, touch;
  spf_lk_e          lk_kind;

  // head compare, lowest-numbered match wins
  always_comb begin
    hit_id = '0;
    for (int i = int'(NSTREAM) - 1; i >= 0; i--) begin
      head_match[i] = hd_vld[i] && (hd_tag[i] == lk_addr);
      if (head_match[i]) hit_id = SID_W'(i);
    end
    hit_any = |head_match;
  end

  always_comb begin
    if (!lk_valid)     lk_kind = LK_IDLE;
    else if (lk_l1_hit) lk_kind = LK_BYPASS;
    else if (hit_any)  lk_kind = LK_HIT;
    else               lk_kind = LK_MISS;
  end

  always_comb begin
    for (int i = 0; i < int'(NSTREAM); i++) begin
      pop[i]    = (lk_kind == LK_HIT)  && (hit_id == SID_W'(i));
      alloc[i]  = (lk_kind == LK_MISS) && (victim_id == SID_W'(i));
      rsp_wr[i] = mem_rsp_valid && (mem_rsp_sid == SID_W'(i));
    end
  end

  assign touch    = (lk_kind == LK_HIT) || (lk_kind == LK_MISS);
  assign touch_id = (lk_kind == LK_HIT) ? hit_id : victim_id;

  spf_lru #(.N(NSTREAM)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_i    (touch),
    .touch_id_i (touch_id),
    .victim_o   (victim_id)
  );

  assign can_issue = !mem_req_valid || mem_req_ready;

  spf_rr_arb #(.N(NSTREAM)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (can_issue),
    .req_i    (room & ~alloc),
    .gnt_o    (grant),
    .gnt_id_o (gnt_id)
  );

  for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
    spf_stream #(
      .DEPTH  (DEPTH),
      .LA_W   (LA_W),
      .LINE_W (LINE_W),
      .GEN_W  (GEN_W)
    ) u_stream (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc[g]),
      .alloc_addr_i (lk_addr),
      .grant_i      (grant[g]),
      .pop_i        (pop[g]),
      .rsp_wr_i     (rsp_wr[g]),
      .rsp_gen_i    (mem_rsp_gen),
      .rsp_data_i   (mem_rsp_data),
      .room_o       (room[g]),
      .head_vld_o   (hd_vld[g]),
      .head_tag_o   (hd_tag[g]),
      .head_data_o  (hd_data[g]),
      .next_addr_o  (nx_addr[g]),
      .gen_o        (st_gen[g])
    );
  end

  // request register: loaded only when empty or being accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_sid   <= '0;
      mem_req_gen   <= '0;
    end else if (can_issue) begin
      mem_req_valid <= |grant;
      if (|grant) begin
        mem_req_addr <= nx_addr[gnt_id];
        mem_req_sid  <= gnt_id;
        mem_req_gen  <= st_gen[gnt_id];
      end
    end
  end

  // refill register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refill_valid <= 1'b0;
      refill_addr  <= '0;
      refill_data  <= '0;
    end else begin
      refill_valid <= (lk_kind == LK_HIT);
      if (lk_kind == LK_HIT) begin
        refill_addr <= lk_addr;
        refill_data <= hd_data[hit_id];
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_sid) && $stable(mem_req_gen))); // R9
  AST_REFILL_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> $past(lk_valid && !lk_l1_hit)); // R6
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop)); // R11
  AST_NO_POP_AND_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !((|pop) && (|alloc))); // R5

endmodule

// File: tb/stream_prefetcher_test.sv
`timescale 1ns/1ps
module stream_prefetcher_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [26:0] lk_addr = '0;
  logic        lk_l1_hit = 1'b0;
  logic        refill_valid;
  logic [26:0] refill_addr;
  logic [63:0] refill_data;
  logic        mem_req_valid, mem_req_ready;
  logic [26:0] mem_req_addr;
  logic [1:0]  mem_req_sid;
  logic [2:0]  mem_req_gen;
  logic        mem_rsp_valid = 1'b0;
  logic [1:0]  mem_rsp_sid = '0;
  logic [2:0]  mem_rsp_gen = '0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stream_prefetcher uut (
    .clk, .rst_n, .lk_valid, .lk_addr, .lk_l1_hit,
    .refill_valid, .refill_addr, .refill_data,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_sid, .mem_req_gen,
    .mem_rsp_valid, .mem_rsp_sid, .mem_rsp_gen, .mem_rsp_data
  );

  // lower-memory model: logs accepted requests, replies in order when enabled
  logic        rdy = 1'b1;
  logic        reply = 1'b1;
  logic [26:0] lg_addr [512];
  int          lg_sid  [512];
  int          lg_n = 0;
  logic [26:0] q_addr [64];
  logic [1:0]  q_sid  [64];
  logic [2:0]  q_gen  [64];
  int          q_wr = 0;
  int          q_rd = 0;

  assign mem_req_ready = rdy;

  function automatic logic [63:0] line_of(input logic [26:0] a);
    return {5'd0, a, 5'd0, ~a};
  endfunction

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && rdy) begin
      lg_addr[lg_n % 512] <= mem_req_addr;
      lg_sid[lg_n % 512]  <= int'(mem_req_sid);
      lg_n                <= lg_n + 1;
      q_addr[q_wr % 64]   <= mem_req_addr;
      q_sid[q_wr % 64]    <= mem_req_sid;
      q_gen[q_wr % 64]    <= mem_req_gen;
      q_wr                <= q_wr + 1;
    end
    if (reply && q_rd != q_wr) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_sid   <= q_sid[q_rd % 64];
      mem_rsp_gen   <= q_gen[q_rd % 64];
      mem_rsp_data  <= line_of(q_addr[q_rd % 64]);
      q_rd          <= q_rd + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic lookup(input logic [26:0] a, input logic l1, output logic v,
                        output logic [26:0] ra, output logic [63:0] rd);
    @(negedge clk);
    lk_valid  = 1'b1;
    lk_addr   = a;
    lk_l1_hit = l1;
    @(posedge clk);
    #1;
    v  = refill_valid;
    ra = refill_addr;
    rd = refill_data;
    lk_valid  = 1'b0;
    lk_l1_hit = 1'b0;
  endtask

  task automatic chk_stream(input int m, input int sid, input logic [26:0] first,
                            input int cnt, input string req);
    int j = 0;
    for (int i = m; i < lg_n; i++) begin
      if (lg_sid[i % 512] == sid) begin
        chk(lg_addr[i % 512] == 27'(first + j), req, lg_addr[i % 512], 27'(first + j));
        j++;
      end
    end
    chk(j == cnt, req, j, cnt);
  endtask

  logic        v;
  logic [26:0] ra;
  logic [63:0] rd;
  int          base_of [4];

  task automatic t_reset;
    idle(5);
    chk(refill_valid == 1'b0, "R1 refill", refill_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 request", mem_req_valid, 0);
    chk(lg_n == 0, "R1 no traffic", lg_n, 0);
  endtask

  task automatic t_first_miss;
    int m = lg_n;
    lookup(27'h100, 1'b0, v, ra, rd);
    chk(v == 1'b0, "R2 miss gives no refill", v, 0);
    idle(20);
    chk_stream(m, 3, 27'h101, 4, "R2 R3 queue 3 run");
  endtask

  task automatic t_hit;
    int m = lg_n;
    lookup(27'h101, 1'b0, v, ra, rd);
    chk(v == 1'b1, "R4 hit valid", v, 1);
    chk(ra == 27'h101, "R4 hit addr", ra, 27'h101);
    chk(rd == line_of(27'h101), "R4 hit data", rd, line_of(27'h101));
    idle(10);
    chk_stream(m, 3, 27'h105, 1, "R4 refetch");
  endtask

  task automatic t_head_only;
    int m = lg_n;
    lookup(27'h103, 1'b0, v, ra, rd);
    chk(v == 1'b0, "R5 deep entry not a hit", v, 0);
    idle(20);
    chk_stream(m, 2, 27'h104, 4, "R5 R7 restart on queue 2");
  endtask

  task automatic t_l1_hit;
    int m = lg_n;
    lookup(27'h102, 1'b1, v, ra, rd);
    chk(v == 1'b0, "R6 bypass no refill", v, 0);
    idle(10);
    chk(lg_n == m, "R6 bypass no requests", lg_n, m);
    lookup(27'h102, 1'b0, v, ra, rd);
    chk(v == 1'b1 && rd == line_of(27'h102), "R6 head kept", rd, line_of(27'h102));
    idle(10);
  endtask

  task automatic t_lru;
    int m = lg_n;
    lookup(27'h200, 1'b0, v, ra, rd);
    idle(20);
    chk_stream(m, 1, 27'h201, 4, "R7 victim queue 1");
    m = lg_n;
    lookup(27'h300, 1'b0, v, ra, rd);
    idle(20);
    chk_stream(m, 0, 27'h301, 4, "R7 victim queue 0");
    m = lg_n;
    lookup(27'h400, 1'b0, v, ra, rd);
    idle(20);
    chk_stream(m, 2, 27'h401, 4, "R7 victim queue 2");
  endtask

  task automatic t_stale;
    int m;
    reply = 1'b0;
    m = lg_n;
    lookup(27'h500, 1'b0, v, ra, rd);
    idle(8);
    chk(lg_sid[m % 512] == 3, "R7 victim queue 3", lg_sid[m % 512], 3);
    lookup(27'h600, 1'b0, v, ra, rd); idle(8);
    lookup(27'h700, 1'b0, v, ra, rd); idle(8);
    lookup(27'h800, 1'b0, v, ra, rd); idle(8);
    m = lg_n;
    lookup(27'h900, 1'b0, v, ra, rd); idle(8);
    chk(lg_sid[m % 512] == 3, "R8 queue 3 restarted", lg_sid[m % 512], 3);
    reply = 1'b1;
    idle(60);
    lookup(27'h901, 1'b0, v, ra, rd);
    chk(v == 1'b1 && rd == line_of(27'h901), "R8 fresh line intact", rd, line_of(27'h901));
    lookup(27'h501, 1'b0, v, ra, rd);
    chk(v == 1'b0, "R8 stale line dropped", v, 0);
    idle(20);
  endtask

  task automatic t_hold;
    int m = lg_n;
    rdy = 1'b0;
    lookup(27'hA00, 1'b0, v, ra, rd);
    idle(1);
    chk(mem_req_valid == 1'b1, "R9 request raised", mem_req_valid, 1);
    chk(mem_req_addr == 27'hA01, "R9 request addr", mem_req_addr, 27'hA01);
    idle(5);
    chk(mem_req_valid == 1'b1 && mem_req_addr == 27'hA01, "R9 held under stall",
        mem_req_addr, 27'hA01);
    rdy = 1'b1;
    idle(20);
    chk(lg_addr[m % 512] == 27'hA01, "R9 accepted after stall", lg_addr[m % 512], 27'hA01);
  endtask

  task automatic t_rr;
    int m;
    int s;
    for (int b = 0; b < 4; b++) begin
      m = lg_n;
      lookup(27'(32'hB00 + b * 32'h100), 1'b0, v, ra, rd);
      idle(12);
      s = lg_sid[m % 512];
      base_of[s] = 32'hB00 + b * 32'h100;
    end
    idle(10);
    rdy = 1'b0;
    lookup(27'(base_of[1] + 1), 1'b0, v, ra, rd);
    chk(v == 1'b1, "R10 setup hit 1", v, 1);
    lookup(27'(base_of[0] + 1), 1'b0, v, ra, rd);
    chk(v == 1'b1, "R10 setup hit 0", v, 1);
    lookup(27'(base_of[3] + 1), 1'b0, v, ra, rd);
    chk(v == 1'b1, "R10 setup hit 3", v, 1);
    m = lg_n;
    rdy = 1'b1;
    idle(10);
    chk(lg_sid[m % 512] == 1, "R10 first grant", lg_sid[m % 512], 1);
    chk(lg_sid[(m + 1) % 512] == 3, "R10 second grant", lg_sid[(m + 1) % 512], 3);
    chk(lg_sid[(m + 2) % 512] == 0, "R10 third grant", lg_sid[(m + 2) % 512], 0);
    chk(lg_addr[(m + 1) % 512] == 27'(base_of[3] + 5), "R10 second addr",
        lg_addr[(m + 1) % 512], 27'(base_of[3] + 5));
  endtask

  task automatic t_dup;
    int m;
    int sa, sb, lo;
    m = lg_n;
    lookup(27'hF00, 1'b0, v, ra, rd); idle(12);
    sa = lg_sid[m % 512];
    m = lg_n;
    lookup(27'hF00, 1'b0, v, ra, rd); idle(12);
    sb = lg_sid[m % 512];
    chk(sa != sb, "R11 two queues", sb, sa);
    lo = (sa < sb) ? sa : sb;
    m = lg_n;
    lookup(27'hF01, 1'b0, v, ra, rd);
    chk(v == 1'b1 && rd == line_of(27'hF01), "R11 shared head hit", rd, line_of(27'hF01));
    idle(8);
    chk(lg_sid[m % 512] == lo, "R11 lower queue popped", lg_sid[m % 512], lo);
    chk(lg_addr[m % 512] == 27'hF05, "R11 refetch addr", lg_addr[m % 512], 27'hF05);
    lookup(27'hF01, 1'b0, v, ra, rd);
    chk(v == 1'b1, "R11 other head kept", v, 1);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_first_miss;
    t_hit;
    t_head_only;
    t_l1_hit;
    t_lru;
    t_stale;
    t_hold;
    t_rr;
    t_dup;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule